// File: doc/BRIEF.md
# Nested Interrupt Controller with Per-Level Mask Words

This block sits between four interrupt sources and a CPU. Source A has index 0, B has 1, C has 2 and D has 3. The block holds one sticky pending flag per source. It raises a single request line toward the CPU, together with the index of the source it grants. Which source wins is decided in two stages. First, a hardware response order puts the lowest index first. Second, a mask word filters out some sources from competing while a routine runs. Software can load a new mask word at any level.

When the CPU acknowledges a grant, the controller does four things. It saves the current mask word and the current active level on a small stack. It loads an entry mask word chosen per source, which software may overwrite. It marks the granted source as active. It drops the global enable, so software decides when nesting may happen. It can re-arm enable right after entry, which allows preemption, or only just before it returns, which gives the single-level behaviour. A return strobe pops the saved mask and active level and re-arms enable. Because each level carries its own mask word, the order in which routines are actually processed can differ from the fixed response order.

Top module: `nest_irq_ctrl`

## Requirements
- R1: Among sources that are pending and not masked, the one with the lowest index (A=0 before B=1 before C=2 before D=3) is granted, and its index appears on `irq_id`.
- R2: An accepted acknowledge clears the global enable. While enable is low, `irq_req` stays low until an `en_set` pulse or an effective return sets it.
- R3: Bit i of the mask word blocks source i. A `mask_we` pulse loads `mask_wdata` in a cycle that has no accepted acknowledge and no effective return. Reset leaves the mask word at all zeros.
- R4: A one-cycle high on `irq_src[i]` sets pending flag i from the next cycle on. The flag stays set until source i is acknowledged.
- R5: An accepted acknowledge saves the mask word and the active level on the stack. It then loads that source's entry mask: A 4'b1111, B 4'b0010, C 4'b0110, D 4'b1110, with bit i standing for source i.
- R6: A return strobe with at least one level nested, and no accepted acknowledge in the same cycle, restores the saved mask word and active level and sets enable. A return with nothing nested changes nothing.
- R7: With the entry masks, enable re-armed after each entry, and all four sources raised together, the grants come in the order A, B, C, D. A completes before B is entered, C preempts B, and D preempts C. The returns then lead to C, then B, then idle.
- R8: While DEPTH levels are nested, no request is raised, even for a pending, unmasked source.
- R9: After reset there is no request and no active level, pending flags are clear, the stack is empty and enable is low.
- R10: An acknowledge while `irq_req` is low is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_src | input | 4 | Request pulses from sources A..D (bit 0 = A) |
| cpu_ack | input | 1 | CPU enters the service routine of the granted source |
| mask_we | input | 1 | Load the current mask word |
| mask_wdata | input | 4 | New mask word, bit i blocks source i |
| en_set | input | 1 | Set the global enable |
| cpu_ret | input | 1 | Return from the current routine |
| irq_req | output | 1 | Interrupt request to the CPU |
| irq_id | output | 2 | Index of the granted source |
| act_busy | output | 1 | A routine is active |
| act_id | output | 2 | Index of the active source |

## Verification
The main function is exercised with four input patterns, and each one separates a different possible fault:
- **All four sources raised at once, using the entry masks.** This distinguishes arbitration by mask word from arbitration by fixed priority alone: a fixed-order design would never let C preempt B.
- **A single request while enable is low.** This shows that enable gates requests, and that the pending flag survives the wait.
- **A low source masked, then a high source raised, while B is active.** This shows that masking stops preemption while a higher source still gets through.
- **Repeated self-nesting of A after clearing its mask.** This drives the stack to its limit and checks that the request is held back there, and that it reappears after one pop.

// File: rtl/nic_pkg.sv
package nic_pkg;
  typedef enum logic [1:0] {
    STK_HOLD = 2'd0,
    STK_PUSH = 2'd1,
    STK_POP  = 2'd2
  } stk_op_e;
endpackage

// File: rtl/nic_pend.sv
module nic_pend #(
  parameter int NSRC = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src_i,
  input  logic [NSRC-1:0] clr_i,
  output logic [NSRC-1:0] pend_o
);
  logic [NSRC-1:0] pend_q, pend_d;

  always_comb begin
    pend_d = (pend_q & ~clr_i) | src_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= pend_d;
  end

  assign pend_o = pend_q;

  AST_PEND_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend_q & $past(pend_q & ~clr_i)) == $past(pend_q & ~clr_i))); // R4
endmodule

// File: rtl/nic_arb.sv
module nic_arb #(
  parameter int NSRC = 4,
  parameter int IDXW = 2
) (
  input  logic [NSRC-1:0] pend_i,
  input  logic [NSRC-1:0] mask_i,
  input  logic            en_i,
  input  logic            room_i,
  output logic            req_o,
  output logic [IDXW-1:0] id_o
);
  logic [NSRC-1:0] elig;

  for (genvar g = 0; g < NSRC; g++) begin : g_elig
    assign elig[g] = pend_i[g] & ~mask_i[g];
  end

  always_comb begin
    id_o = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (elig[i]) id_o = IDXW'(i);
    end
  end

  assign req_o = en_i & room_i & (|elig);
endmodule

// File: rtl/nic_stack.sv
module nic_stack
  import nic_pkg::*;
#(
  parameter int NSRC  = 4,
  parameter int DEPTH = 4,
  parameter int IDXW  = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  stk_op_e         op_i,
  input  logic [NSRC-1:0] push_mask_i,
  input  logic [IDXW-1:0] push_act_i,
  input  logic            push_busy_i,
  output logic [NSRC-1:0] top_mask_o,
  output logic [IDXW-1:0] top_act_o,
  output logic            top_busy_o,
  output logic            full_o,
  output logic            empty_o
);
  localparam int SPW  = $clog2(DEPTH + 1);
  localparam int PTRW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [SPW-1:0]  sp_q, sp_d;
  logic [NSRC-1:0] mask_mem [DEPTH];
  logic [IDXW-1:0] act_mem  [DEPTH];
  logic            busy_mem [DEPTH];
  logic [PTRW-1:0] top_ptr;

  always_comb begin
    sp_d = sp_q;
    case (op_i)
      STK_PUSH: sp_d = sp_q + 1'b1;
      STK_POP:  sp_d = sp_q - 1'b1;
      default:  sp_d = sp_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sp_q <= '0;
    else        sp_q <= sp_d;
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    logic wr_en;
    assign wr_en = (op_i == STK_PUSH) && (sp_q == SPW'(g));
    always_ff @(posedge clk) begin
      if (wr_en) begin
        mask_mem[g] <= push_mask_i;
        act_mem[g]  <= push_act_i;
        busy_mem[g] <= push_busy_i;
      end
    end
  end

  assign top_ptr    = PTRW'(sp_q - 1'b1);
  assign top_mask_o = mask_mem[top_ptr];
  assign top_act_o  = act_mem[top_ptr];
  assign top_busy_o = busy_mem[top_ptr];
  assign full_o     = (sp_q == SPW'(DEPTH));
  assign empty_o    = (sp_q == '0);

  AST_SP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    sp_q <= SPW'(DEPTH)); // R8
  AST_NO_PUSH_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    full_o |-> op_i != STK_PUSH); // R8
  AST_NO_POP_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    empty_o |-> op_i != STK_POP); // R6
endmodule

// File: rtl/nest_irq_ctrl.sv
module nest_irq_ctrl
  import nic_pkg::*;
#(
  parameter int NSRC  = 4,
  parameter int DEPTH = 4,
  parameter logic [NSRC*NSRC-1:0] ENTRY_MASK = 16'b1110_0110_0010_1111
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NSRC-1:0]           irq_src,
  input  logic                      cpu_ack,
  input  logic                      mask_we,
  input  logic [NSRC-1:0]           mask_wdata,
  input  logic                      en_set,
  input  logic                      cpu_ret,
  output logic                      irq_req,
  output logic [$clog2(NSRC)-1:0]   irq_id,
  output logic                      act_busy,
  output logic [$clog2(NSRC)-1:0]   act_id
);
  localparam int IDXW = $clog2(NSRC);
  localparam logic [NSRC-1:0] ONE = NSRC'(1);

  logic [NSRC-1:0] pend;
  logic [NSRC-1:0] clr_vec;
  logic [NSRC-1:0] mask_q, mask_d;
  logic            en_q, en_d;
  logic            busy_q, busy_d;
  logic [IDXW-1:0] act_q, act_d;
  logic            take, do_pop;
  logic            full, empty;
  logic [NSRC-1:0] top_mask;
  logic [IDXW-1:0] top_act;
  logic            top_busy;
  stk_op_e         op;

  nic_pend #(.NSRC(NSRC)) u_pend (
    .clk    (clk),
    .rst_n  (rst_n),
    .src_i  (irq_src),
    .clr_i  (clr_vec),
    .pend_o (pend)
  );

  nic_arb #(.NSRC(NSRC), .IDXW(IDXW)) u_arb (
    .pend_i (pend),
    .mask_i (mask_q),
    .en_i   (en_q),
    .room_i (~full),
    .req_o  (irq_req),
    .id_o   (irq_id)
  );

  nic_stack #(.NSRC(NSRC), .DEPTH(DEPTH), .IDXW(IDXW)) u_stack (
    .clk         (clk),
    .rst_n       (rst_n),
    .op_i        (op),
    .push_mask_i (mask_q),
    .push_act_i  (act_q),
    .push_busy_i (busy_q),
    .top_mask_o  (top_mask),
    .top_act_o   (top_act),
    .top_busy_o  (top_busy),
    .full_o      (full),
    .empty_o     (empty)
  );

  assign take    = cpu_ack & irq_req;
  assign do_pop  = cpu_ret & ~take & ~empty;
  assign clr_vec = take ? (ONE << irq_id) : '0;

  always_comb begin
    op = STK_HOLD;
    if (take)        op = STK_PUSH;
    else if (do_pop) op = STK_POP;
  end

  always_comb begin
    mask_d = mask_q;
    en_d   = en_q;
    busy_d = busy_q;
    act_d  = act_q;
    if (take) begin
      mask_d = ENTRY_MASK[irq_id*NSRC +: NSRC];
      en_d   = 1'b0;
      busy_d = 1'b1;
      act_d  = irq_id;
    end else if (do_pop) begin
      mask_d = top_mask;
      en_d   = 1'b1;
      busy_d = top_busy;
      act_d  = top_act;
    end else begin
      if (mask_we) mask_d = mask_wdata;
      if (en_set)  en_d   = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      en_q   <= 1'b0;
      busy_q <= 1'b0;
      act_q  <= '0;
    end else begin
      mask_q <= mask_d;
      en_q   <= en_d;
      busy_q <= busy_d;
      act_q  <= act_d;
    end
  end

  assign act_busy = busy_q;
  assign act_id   = act_q;

  AST_HIGHEST_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> ((pend & ~mask_q & ((ONE << irq_id) - ONE)) == '0)); // R1
  AST_GRANT_UNMASKED: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (pend[irq_id] && !mask_q[irq_id])); // R3
  AST_ENTRY_DROPS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> !irq_req); // R2
  AST_ENTRY_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> (act_busy && act_id == $past(irq_id))); // R5
  AST_POP_RESTORES: assert property (@(posedge clk) disable iff (!rst_n)
    do_pop |=> (en_q && act_q == $past(top_act) && mask_q == $past(top_mask))); // R6
  AST_IDLE_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_ack && !irq_req && !cpu_ret && !mask_we) |=> ($stable(act_busy) && $stable(mask_q))); // R10
endmodule

// File: tb/nest_irq_ctrl_tb.sv
module nest_irq_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [3:0] irq_src;
  logic       cpu_ack, mask_we, en_set, cpu_ret;
  logic [3:0] mask_wdata;
  logic       irq_req, act_busy;
  logic [1:0] irq_id, act_id;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;
  int exp_q[$];

  always #2 clk = ~clk;

  nest_irq_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .irq_src(irq_src), .cpu_ack(cpu_ack),
    .mask_we(mask_we), .mask_wdata(mask_wdata), .en_set(en_set),
    .cpu_ret(cpu_ret), .irq_req(irq_req), .irq_id(irq_id),
    .act_busy(act_busy), .act_id(act_id)
  );

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Monitor: pop expected grant when an acknowledge is presented (-1 = no request expected)
  always @(negedge clk) begin
    if (rst_n && cpu_ack) begin
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R1 actual=unexpected_ack expected=none");
      end else begin
        int e;
        e = exp_q.pop_front();
        if (e < 0) chk("R10 no request on stray ack", int'(irq_req), 0);
        else begin
          chk("R1 request at ack", int'(irq_req), 1);
          chk("R1 granted id", int'(irq_id), e);
        end
      end
    end
  end

  task automatic step();
    @(posedge clk); #1;
    irq_src = '0; cpu_ack = 0; mask_we = 0; en_set = 0; cpu_ret = 0;
  endtask
  task automatic settle(); @(negedge clk); endtask
  task automatic raise(input logic [3:0] v); irq_src = v; step(); endtask
  task automatic grant(input int id); exp_q.push_back(id); cpu_ack = 1; step(); endtask
  task automatic arm(); en_set = 1; step(); endtask
  task automatic ret(); cpu_ret = 1; step(); endtask
  task automatic wmask(input logic [3:0] m); mask_we = 1; mask_wdata = m; step(); endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 0; irq_src = '0; cpu_ack = 0; mask_we = 0; mask_wdata = '0;
    en_set = 0; cpu_ret = 0;
    repeat (3) @(posedge clk); #1; rst_n = 1;
    settle();
    chk("R9 reset irq_req", int'(irq_req), 0);
    chk("R9 reset act_busy", int'(act_busy), 0);

    grant(-1); settle();
    chk("R10 stray ack leaves idle", int'(act_busy), 0);

    raise(4'b0010); settle();
    chk("R2 enable low blocks request", int'(irq_req), 0);
    arm(); settle();
    chk("R4 pending held until enable", int'(irq_req), 1);
    chk("R4 pending id B", int'(irq_id), 1);

    raise(4'b1101); settle();
    chk("R1 A wins over all", int'(irq_id), 0);

    // R7 nested scenario
    grant(0); settle();
    chk("R2 entry clears enable", int'(irq_req), 0);
    chk("R7 active A", int'(act_id), 0);
    arm(); settle();
    chk("R5 entry mask of A blocks all", int'(irq_req), 0);
    ret(); settle();
    chk("R6 return to idle", int'(act_busy), 0);
    chk("R7 B next", int'(irq_id), 1);
    grant(1); arm(); settle();
    chk("R5 B mask lets C preempt", int'(irq_id), 2);
    grant(2); arm(); settle();
    chk("R7 D preempts C", int'(irq_id), 3);
    grant(3); arm(); settle();
    chk("R7 nothing left", int'(irq_req), 0);
    chk("R7 active D", int'(act_id), 3);
    ret(); settle();
    chk("R7 D returns to C", int'(act_id), 2);
    ret(); settle();
    chk("R7 C returns to B", int'(act_id), 1);
    ret(); settle();
    chk("R7 B returns to idle", int'(act_busy), 0);

    // R3 mask write at idle
    wmask(4'b0001); raise(4'b0001); settle();
    chk("R3 masked A not requested", int'(irq_req), 0);
    wmask(4'b0000); settle();
    chk("R3 unmasked A requested", int'(irq_req), 1);

    // R8 depth limit through self-nesting of A
    grant(0);
    for (int k = 0; k < 3; k++) begin
      wmask(4'b0000); arm(); raise(4'b0001); grant(0);
    end
    wmask(4'b0000); arm(); raise(4'b0001); settle();
    chk("R8 full stack holds request", int'(irq_req), 0);
    ret(); settle();
    chk("R8 request after one pop", int'(irq_req), 1);
    grant(0);
    for (int k = 0; k < 4; k++) ret();
    settle();
    chk("R6 unwound to idle", int'(act_busy), 0);
    ret(); settle();
    chk("R6 return at empty ignored", int'(act_busy), 0);

    // R3 masking stops low source, higher still preempts
    raise(4'b0010); grant(1);
    wmask(4'b1110); arm(); raise(4'b1000); settle();
    chk("R3 masked D does not preempt B", int'(irq_req), 0);
    raise(4'b0001); settle();
    chk("R1 A preempts B", int'(irq_id), 0);
    grant(0); ret(); settle();
    chk("R6 back in B", int'(act_id), 1);
    chk("R3 D still masked in B", int'(irq_req), 0);
    ret(); settle();
    chk("R4 D kept pending, granted at idle", int'(irq_id), 3);
    grant(3); ret(); settle();
    chk("R6 final idle", int'(act_busy), 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule